// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a simple synchronous host port and an asynchronous static RAM with a shared data bus. A host raises `req` with `we`, an address and, for a write, a data word. When the sequencer is idle it takes the request, latches the address and the data, and then drives the RAM's active-low chip-select, output-enable and write-enable strobes. Every strobe edge is placed a fixed number of clock cycles from the one before it, so the RAM's setup, pulse-width, hold and access limits are met.

The data pins are split into an output word, an output-enable that controls the pad's tristate buffer, and an input word. The output-enable is raised only around write strobes. After a read, the sequencer waits out the RAM's output-disable time before it takes another request, so the RAM and the pad never drive the bus together. `done` pulses for one cycle when an access finishes; for a read, `rdata` holds the captured word from that cycle until the next read finishes. Each interval is a parameter counted in whole clock cycles, with a minimum of one.

Top module: `sram_ctl`

## Requirements
- R1: During reset and just after it, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `done` is 0 and `ready` is 1.
- R2: A write taken at a clock edge is followed by exactly T_AS cycles with `sram_dq_oe` = 1, `sram_dq_out` equal to the request data and all three strobes high.
- R3: The write strobe phase that follows lasts max(T_WP, T_DS) cycles, with `sram_cs_n` = 0, `sram_we_n` = 0 and `sram_oe_n` = 1. `sram_we_n` is never low unless `sram_cs_n` is low.
- R4: After the write strobes rise, the strobes stay high for max(T_DH, T_AH) cycles. `sram_dq_oe` stays 1 for the first T_DH of those cycles and is 0 for the rest.
- R5: A read taken at a clock edge is followed by exactly T_ACC cycles with `sram_cs_n` = 0, `sram_oe_n` = 0, `sram_we_n` = 1 and `sram_dq_oe` = 0.
- R6: Read data is sampled from `sram_dq_in` at the end of the last read access cycle. It appears on `rdata` in the cycle where `done` is 1.
- R7: After a read access, T_OZ cycles follow with all strobes high, `sram_dq_oe` = 0 and `ready` = 0. No request is taken during them.
- R8: `done` is 1 for exactly one cycle per access: T_AS+max(T_WP,T_DS)+max(T_DH,T_AH) cycles after a write is taken, and T_ACC cycles after a read is taken. `ready` is 1 only when idle, and `req` while busy is ignored.
- R9: `sram_addr` equals the address of the request that was taken, from the cycle after it is taken until the access is complete.
- R10: `sram_dq_oe` is never 1 while `sram_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host request; taken when `ready` is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Request address |
| wdata | input | DW | Write data |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last word read |
| sram_addr | output | AW | RAM address pins |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | DW | Word driven onto the data pads |
| sram_dq_oe | output | 1 | Pad driver enable for `sram_dq_out` |
| sram_dq_in | input | DW | Word sensed on the data pads |

## Verification
Two events can fall in one cycle here. The first is completion: `done` and the return to idle arrive together, and the next host request is presented in that same cycle. For a read, the first is instead the `done` pulse together with the first output-disable cycle. The bench holds `req` high with altered fields all through each busy window, then issues the next operation in the completion cycle. Every cycle it compares the strobes, `ready`, `done` and `sram_addr` against a per-cycle expected pattern. A request taken too early shows up as a wrong address or a broken phase sequence. The RAM model in the bench returns inverted data until the access time has passed, so a capture made one cycle early yields a wrong `rdata`.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACC   = 3'd4,
        PH_RTURN  = 3'd5
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBES_OFF = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CW    = 4,
    parameter int T_AS  = 2,
    parameter int PW    = 4,
    parameter int HL    = 2,
    parameter int T_ACC = 3,
    parameter int T_OZ  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          we,
    input  logic          zero,
    output phase_e        phase,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept,
    output logic          capture,
    output logic          done
);

    localparam logic [CW-1:0] LD_AS  = CW'(T_AS - 1);
    localparam logic [CW-1:0] LD_PW  = CW'(PW - 1);
    localparam logic [CW-1:0] LD_HL  = CW'(HL - 1);
    localparam logic [CW-1:0] LD_ACC = CW'(T_ACC - 1);
    localparam logic [CW-1:0] LD_OZ  = CW'(T_OZ - 1);

    phase_e phase_nx;
    logic   finish;

    always_comb begin
        phase_nx = phase;
        load     = 1'b0;
        load_val = '0;
        finish   = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (req) begin
                    load = 1'b1;
                    if (we) begin
                        phase_nx = PH_WSETUP;
                        load_val = LD_AS;
                    end else begin
                        phase_nx = PH_RACC;
                        load_val = LD_ACC;
                    end
                end
            end
            PH_WSETUP: begin
                if (zero) begin
                    phase_nx = PH_WPULSE;
                    load     = 1'b1;
                    load_val = LD_PW;
                end
            end
            PH_WPULSE: begin
                if (zero) begin
                    phase_nx = PH_WHOLD;
                    load     = 1'b1;
                    load_val = LD_HL;
                end
            end
            PH_WHOLD: begin
                if (zero) begin
                    phase_nx = PH_IDLE;
                    finish   = 1'b1;
                end
            end
            PH_RACC: begin
                if (zero) begin
                    phase_nx = PH_RTURN;
                    load     = 1'b1;
                    load_val = LD_OZ;
                    finish   = 1'b1;
                end
            end
            PH_RTURN: begin
                if (zero) begin
                    phase_nx = PH_IDLE;
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    assign accept  = (phase == PH_IDLE) && req;
    assign capture = (phase == PH_RACC) && zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= finish;
        end
    end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_ctl_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int CW   = 4,
    parameter int HL   = 2,
    parameter int T_DH = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic [CW-1:0] cnt,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] sram_addr,
    output strobe_t       strobes,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [DW-1:0] rdata
);

    // Hold-phase counter values at or above this mark still belong to data hold.
    localparam logic [CW-1:0] DRIVE_MARK = CW'(HL - T_DH);

    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr <= '0;
            dq_out    <= '0;
            rdata     <= '0;
        end else begin
            if (accept) begin
                sram_addr <= addr;
                dq_out    <= wdata;
            end
            if (capture) begin
                rdata <= dq_in;
            end
        end
    end

    always_comb begin
        strobes = STROBES_OFF;
        dq_oe   = 1'b0;
        case (phase)
            PH_WSETUP: dq_oe = 1'b1;
            PH_WPULSE: begin
                strobes.cs_n = 1'b0;
                strobes.we_n = 1'b0;
                dq_oe        = 1'b1;
            end
            PH_WHOLD:  dq_oe = (cnt >= DRIVE_MARK);
            PH_RACC: begin
                strobes.cs_n = 1'b0;
                strobes.oe_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int T_AS  = 2,
    parameter int T_WP  = 3,
    parameter int T_DS  = 4,
    parameter int T_DH  = 1,
    parameter int T_AH  = 2,
    parameter int T_ACC = 3,
    parameter int T_OZ  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_cs_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);

    localparam int PW      = imax(T_WP, T_DS);
    localparam int HL      = imax(T_DH, T_AH);
    localparam int LONGEST = imax(imax(T_AS, PW), imax(HL, imax(T_ACC, T_OZ)));
    localparam int CW      = $clog2(LONGEST + 1);

    phase_e        phase;
    logic          load;
    logic [CW-1:0] load_val;
    logic [CW-1:0] cnt;
    logic          zero;
    logic          accept;
    logic          capture;
    strobe_t       strobes;

    sram_cycle_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .cnt      (cnt),
        .zero     (zero)
    );

    sram_phase_fsm #(
        .CW(CW), .T_AS(T_AS), .PW(PW), .HL(HL), .T_ACC(T_ACC), .T_OZ(T_OZ)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .we       (we),
        .zero     (zero),
        .phase    (phase),
        .load     (load),
        .load_val (load_val),
        .accept   (accept),
        .capture  (capture),
        .done     (done)
    );

    sram_pin_drive #(
        .AW(AW), .DW(DW), .CW(CW), .HL(HL), .T_DH(T_DH)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .cnt       (cnt),
        .accept    (accept),
        .capture   (capture),
        .addr      (addr),
        .wdata     (wdata),
        .dq_in     (sram_dq_in),
        .sram_addr (sram_addr),
        .strobes   (strobes),
        .dq_out    (sram_dq_out),
        .dq_oe     (sram_dq_oe),
        .rdata     (rdata)
    );

    assign ready     = (phase == PH_IDLE);
    assign sram_cs_n = strobes.cs_n;
    assign sram_we_n = strobes.we_n;
    assign sram_oe_n = strobes.oe_n;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ready,
    input logic          done,
    input logic [AW-1:0] sram_addr,
    input logic          sram_cs_n,
    input logic          sram_oe_n,
    input logic          sram_we_n,
    input logic          sram_dq_oe
);

    // R10
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
        !(sram_dq_oe && !sram_oe_n));

    // R3
    we_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_cs_n);

    // R5
    read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> sram_we_n);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> sram_dq_oe);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && $past(!ready)) |-> $stable(sram_addr));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .done       (done),
    .sram_addr  (sram_addr),
    .sram_cs_n  (sram_cs_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int T_AS  = 2;
    localparam int T_WP  = 3;
    localparam int T_DS  = 4;
    localparam int T_DH  = 1;
    localparam int T_AH  = 2;
    localparam int T_ACC = 3;
    localparam int T_OZ  = 2;
    localparam int B_PW  = (T_WP > T_DS) ? T_WP : T_DS;
    localparam int B_HL  = (T_DH > T_AH) ? T_DH : T_AH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          ready, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sram_ctl #(
        .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_DS(T_DS),
        .T_DH(T_DH), .T_AH(T_AH), .T_ACC(T_ACC), .T_OZ(T_OZ)
    ) u_sram_ctl (
        .clk(clk), .rst(rst), .req(req), .we(we_i), .addr(addr_i), .wdata(wdata_i),
        .ready(ready), .done(done), .rdata(rdata), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // RAM model: stores on clock edges inside the write strobe; reads return
    // inverted data until the access time has elapsed.
    logic [DW-1:0] mem [16];
    int            acc_cnt = 0;
    logic [DW-1:0] ref_mem [16];

    always @(posedge clk) begin
        if (!sram_cs_n && !sram_we_n && sram_dq_oe) mem[sram_addr[3:0]] <= sram_dq_out;
        if (!sram_cs_n && !sram_oe_n) acc_cnt <= acc_cnt + 1;
        else acc_cnt <= 0;
    end

    assign sram_dq_in = (!sram_cs_n && !sram_oe_n && acc_cnt >= T_ACC - 1)
                        ? mem[sram_addr[3:0]] : ~mem[sram_addr[3:0]];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Expected {cs_n, we_n, oe_n, dq_oe, ready, done} k cycles after acceptance.
    function automatic logic [5:0] exp_pins(input bit w, input int k);
        if (w) begin
            if (k < T_AS) return 6'b111100;
            if (k < T_AS + B_PW) return 6'b001100;
            if (k < T_AS + B_PW + B_HL)
                return {3'b111, (k - T_AS - B_PW) < T_DH, 2'b00};
            return 6'b111011;
        end
        if (k < T_ACC) return 6'b010000;
        if (k < T_ACC + T_OZ) return {5'b11100, k == T_ACC};
        return 6'b111010;
    endfunction

    function automatic string tag_of(input bit w, input int k);
        if (w) begin
            if (k < T_AS) return "R2 write setup";
            if (k < T_AS + B_PW) return "R3 write pulse";
            if (k < T_AS + B_PW + B_HL) return "R4 write hold";
            return "R8 write completion";
        end
        if (k < T_ACC) return "R5 read access";
        if (k < T_ACC + T_OZ) return "R7 read turnaround";
        return "R8 read completion";
    endfunction

    task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit poke);
        int last;
        logic [5:0] got;
        logic [5:0] exp;
        last = w ? (T_AS + B_PW + B_HL) : (T_ACC + T_OZ);
        chk(ready === 1'b1, "R8 ready before request", 32'(ready), 32'd1);
        req = 1'b1; we_i = w; addr_i = a; wdata_i = d;
        @(posedge clk);
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            got = {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ready, done};
            exp = exp_pins(w, k);
            chk(got === exp, tag_of(w, k), 32'(got), 32'(exp));
            if (k < last)
                chk(sram_addr === a, "R9 address held", 32'(sram_addr), 32'(a));
            if (w && sram_dq_oe)
                chk(sram_dq_out === d, "R2 write data on pads", 32'(sram_dq_out), 32'(d));
            if (!w && k == T_ACC)
                chk(rdata === ref_mem[a[3:0]], "R6 read data",
                    32'(rdata), 32'(ref_mem[a[3:0]]));
            if (k < last && poke) begin
                req = 1'b1; we_i = ~w; addr_i = ~a; wdata_i = ~d;
            end else begin
                req = 1'b0;
            end
        end
        if (w) ref_mem[a[3:0]] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        void'($urandom(32'h5A17_C0DE));
        repeat (3) @(negedge clk);
        // R1: quiet pins during reset
        chk({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ready, done} === 6'b111010,
            "R1 in reset", 32'({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ready, done}),
            32'h3A);
        rst = 1'b0;
        @(negedge clk);
        chk({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ready, done} === 6'b111010,
            "R1 after reset", 32'({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ready, done}),
            32'h3A);

        // Fill every model location so later reads have known contents.
        for (int i = 0; i < 16; i++) begin
            a = {AW'($urandom) & ~AW'(16'hF)} | AW'(i);
            d = DW'($urandom);
            do_op(1'b1, a, d, 1'b0);
        end

        // Directed: read right after write, write right after read, busy pokes (R7, R8).
        do_op(1'b1, 16'h1235, 16'hA5A5, 1'b1);
        do_op(1'b0, 16'h1235, 16'h0000, 1'b1);
        do_op(1'b1, 16'hFFF5, 16'h5A5A, 1'b0);
        do_op(1'b0, 16'h0005, 16'h0000, 1'b0);
        do_op(1'b0, 16'h000F, 16'h0000, 1'b1);
        do_op(1'b1, 16'h000F, 16'hFFFF, 1'b1);
        do_op(1'b0, 16'h800F, 16'h0000, 1'b0);

        // Constrained random mix.
        for (int n = 0; n < 120; n++) begin
            a = AW'($urandom);
            d = DW'($urandom);
            do_op(1'($urandom), a, d, 1'($urandom));
        end

        // Idle with no request: nothing moves (R8).
        repeat (4) @(negedge clk);
        chk({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ready, done} === 6'b111010,
            "R8 idle quiet", 32'({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ready, done}),
            32'h3A);

        summary();
        $finish;
    end

endmodule